// File: doc/BRIEF.md
# Crest Factor Overcurrent Fault Detector

This block watches digitised current samples of the low-side switch of a half-bridge and flags a dangerous current waveform. It does not compare the current against a fixed level. It compares the peak current of each switching cycle with a running average of the current, so a resistive sense element whose value drifts with temperature cancels out. A cycle is a violation when its peak is more than three times the average. A fault is raised only after a run of consecutive violating cycles, so single noisy cycles are ignored.

Samples count only while the low-side on-window is open. At each end-of-cycle strobe the block closes the cycle. It judges the peak against the average built from earlier cycles, updates the violation counter, and then folds the mean current of this cycle into an exponential moving average. Detection runs only while an enable input is high, which corresponds to the ignition ramp having passed its arming point. The fault is sticky. It clears only on the clear input, which stands for a supply recycle through the undervoltage thresholds.

Top module: `cf_overcurrent_guard`

## Requirements
- R1: After reset `faultFlag` is low.
- R2: A sample is taken only when `sampleValid` and `loWindow` are both high on a clock edge. Samples that arrive with `loWindow` low have no effect on the peak, the mean or the fault.
- R3: The peak, sum and sample count of a cycle restart on the first clock edge where `loWindow` is high after being low. A large peak from an earlier window never carries into a later one.
- R4: The mean of a cycle is sum divided by sample count, truncated. The average is held scaled by 2^EMA_SHIFT (EMA_SHIFT = 4 by default).
  - The first cycle with samples after reset or clear seeds the scaled average with mean << EMA_SHIFT.
  - Each later cycle with samples sets scaled = scaled - (scaled >> EMA_SHIFT) + mean.
  - The average used in comparisons is scaled >> EMA_SHIFT.
- R5: At the end-of-cycle strobe, a cycle violates when the average is seeded, the window held at least one sample, and peak > 2*avg + avg, using the average from before this cycle's update. A peak equal to three times the average is not a violation.
- R6: Each violating cycle increments a counter. A non-violating cycle resets the counter to zero, so only consecutive violations count.
- R7: On the clock edge that samples the end-of-cycle strobe of the VIOL_LIMIT-th consecutive violating cycle (70 by default), `faultFlag` goes high. It is visible from the following cycle.
- R8: While `detectEn` is low the counter is held at zero and no fault can be raised. The average keeps updating.
- R9: Once high, `faultFlag` stays high whatever the other inputs do, until `faultClear` is high on a clock edge. That edge clears the fault and the counter and unseeds the average. Clear takes priority over a fault being set on the same edge.
- R10: A window with no accepted samples is a non-violating cycle and leaves the average unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleData | input | SAMPLE_W | Unsigned current sample |
| sampleValid | input | 1 | Sample qualifier |
| loWindow | input | 1 | High while the low-side switch is on |
| cycleEnd | input | 1 | One-clock strobe closing a switching cycle |
| detectEn | input | 1 | Arms violation counting |
| faultClear | input | 1 | Synchronous clear of fault, counter and average seed |
| faultFlag | output | 1 | Latched crest factor fault |

## Verification
The bench builds the block with its default parameters: 10-bit samples, a 6-bit per-window sample count, an averaging shift of 4 and a limit of 70 consecutive violations. The full 70-cycle run, and runs of 69 that must not trip, are therefore exercised for real rather than at a shrunken limit. The 10-bit range admits peaks near 1000 against averages near 100, so runs can be built that violate steadily while the moving average drifts. It also admits windows whose mean is held exactly at the seed, so that peaks of exactly 3x and 3x+1 land on both sides of the comparison.

// File: rtl/cf_guard_pkg.sv
package cf_guard_pkg;

  // Strobes passed from the control module to the datapath each clock.
  typedef struct packed {
    logic winStart;    // first clock of a newly opened low-side window
    logic takeSample;  // accept sampleData this clock
    logic closeCycle;  // end of the switching cycle
  } cfStrobe_t;

endpackage

// File: rtl/cf_mean_div.sv
// Per-cycle mean: sum divided by count, zero when no samples were taken.
module cf_mean_div #(
  parameter int SUM_W = 16,
  parameter int CNT_W = 6,
  parameter int OUT_W = 10
) (
  input  logic [SUM_W-1:0] sumIn,
  input  logic [CNT_W-1:0] cntIn,
  output logic [OUT_W-1:0] meanOut
);

  logic [SUM_W-1:0] quot;

  always_comb begin
    if (cntIn == '0) quot = '0;
    else             quot = sumIn / SUM_W'(cntIn);
    meanOut = OUT_W'(quot);
  end

endmodule

// File: rtl/cf_guard_datapath.sv
module cf_guard_datapath
  import cf_guard_pkg::*;
#(
  parameter int SAMPLE_W  = 10,
  parameter int WIN_CNT_W = 6,
  parameter int EMA_SHIFT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfStrobe_t           strb,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                seedClear,
  output logic                violation
);

  localparam int SUM_W = SAMPLE_W + WIN_CNT_W;
  localparam int AVG_W = SAMPLE_W + EMA_SHIFT;
  localparam int CMP_W = SAMPLE_W + 2;

  logic [SAMPLE_W-1:0]  peakReg;
  logic [SUM_W-1:0]     sumReg;
  logic [WIN_CNT_W-1:0] cntReg;
  logic [AVG_W-1:0]     avgAcc;
  logic                 seeded;

  logic [SAMPLE_W-1:0]  meanVal;
  logic [SAMPLE_W-1:0]  avgInt;
  logic [CMP_W-1:0]     limitVal;
  logic [AVG_W-1:0]     avgNext;
  logic                 cntFull;

  cf_mean_div #(
    .SUM_W (SUM_W),
    .CNT_W (WIN_CNT_W),
    .OUT_W (SAMPLE_W)
  ) uMean (
    .sumIn   (sumReg),
    .cntIn   (cntReg),
    .meanOut (meanVal)
  );

  assign cntFull  = &cntReg;
  assign avgInt   = SAMPLE_W'(avgAcc >> EMA_SHIFT);
  assign limitVal = (CMP_W'(avgInt) << 1) + CMP_W'(avgInt);
  assign avgNext  = avgAcc - (avgAcc >> EMA_SHIFT) + AVG_W'(meanVal);

  // Judged against the average of earlier cycles, before this cycle folds in.
  assign violation = strb.closeCycle && seeded && (cntReg != '0) &&
                     (CMP_W'(peakReg) > limitVal);

  // Window accumulation: peak, sum and count.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      peakReg <= '0;
      sumReg  <= '0;
      cntReg  <= '0;
    end else if (strb.winStart) begin
      peakReg <= strb.takeSample ? sampleData : '0;
      sumReg  <= strb.takeSample ? SUM_W'(sampleData) : '0;
      cntReg  <= strb.takeSample ? WIN_CNT_W'(1) : '0;
    end else if (strb.takeSample) begin
      if (sampleData > peakReg) peakReg <= sampleData;
      if (!cntFull) begin
        sumReg <= sumReg + SUM_W'(sampleData);
        cntReg <= cntReg + WIN_CNT_W'(1);
      end
    end
  end

  // Exponential moving average of per-cycle mean, scaled by 2^EMA_SHIFT.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      avgAcc <= '0;
      seeded <= 1'b0;
    end else if (seedClear) begin
      avgAcc <= '0;
      seeded <= 1'b0;
    end else if (strb.closeCycle && (cntReg != '0)) begin
      if (!seeded) begin
        avgAcc <= AVG_W'(meanVal) << EMA_SHIFT;
        seeded <= 1'b1;
      end else begin
        avgAcc <= avgNext;
      end
    end
  end

  // R2: without an accepted sample or a window start, peak and sum hold.
  assert_ignored_sample_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.takeSample && !strb.winStart) |=> ($stable(peakReg) && $stable(sumReg)));

  // R2: an accepted sample inside an open window is never above the peak.
  assert_peak_covers_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeSample && !strb.winStart) |=> (peakReg >= $past(sampleData)));

  // R3: a new window restarts the count.
  assert_window_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.winStart |=> (cntReg <= WIN_CNT_W'(1)));

  // R10: an empty window never violates.
  assert_empty_window_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.closeCycle && (cntReg == '0)) |-> !violation);

endmodule

// File: rtl/cf_guard_ctrl.sv
module cf_guard_ctrl
  import cf_guard_pkg::*;
#(
  parameter int VIOL_LIMIT = 70
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      loWindow,
  input  logic      sampleValid,
  input  logic      cycleEnd,
  input  logic      detectEn,
  input  logic      faultClear,
  input  logic      violation,
  output cfStrobe_t strb,
  output logic      seedClear,
  output logic      faultFlag
);

  localparam int VC_W = $clog2(VIOL_LIMIT + 1);
  localparam logic [VC_W-1:0] LAST_CNT = VC_W'(VIOL_LIMIT - 1);

  logic            loWinQ;
  logic [VC_W-1:0] violCnt;
  logic            hitLimit;

  always_comb begin
    strb.winStart   = loWindow && !loWinQ;
    strb.takeSample = loWindow && sampleValid;
    strb.closeCycle = cycleEnd;
  end

  assign seedClear = faultClear;
  assign hitLimit  = detectEn && violation && (violCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loWinQ <= 1'b0;
    else       loWinQ <= loWindow;
  end

  // Consecutive-violation counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violCnt <= '0;
    end else if (faultClear || !detectEn) begin
      violCnt <= '0;
    end else if (strb.closeCycle) begin
      if (!violation || hitLimit) violCnt <= '0;
      else                        violCnt <= violCnt + VC_W'(1);
    end
  end

  // Sticky fault.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         faultFlag <= 1'b0;
    else if (faultClear) faultFlag <= 1'b0;
    else if (hitLimit)   faultFlag <= 1'b1;
  end

  // R6: the counter never reaches the limit value.
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    violCnt < VC_W'(VIOL_LIMIT));

  // R6: a clean cycle zeroes the run.
  assert_clean_resets_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.closeCycle && !violation) |=> (violCnt == '0));

  // R7: a fault only rises after a violating close while armed.
  assert_fault_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultFlag) |-> ($past(violation) && $past(detectEn) && $past(cycleEnd)));

  // R8: disarmed detection holds the counter at zero.
  assert_disarm_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !detectEn |=> (violCnt == '0));

  // R9: the fault is sticky until cleared.
  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !faultClear) |=> faultFlag);

  // R9: a clear always wins.
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    faultClear |=> !faultFlag);

endmodule

// File: rtl/cf_overcurrent_guard.sv
module cf_overcurrent_guard
  import cf_guard_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int WIN_CNT_W  = 6,
  parameter int EMA_SHIFT  = 4,
  parameter int VIOL_LIMIT = 70
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                sampleValid,
  input  logic                loWindow,
  input  logic                cycleEnd,
  input  logic                detectEn,
  input  logic                faultClear,
  output logic                faultFlag
);

  cfStrobe_t strb;
  logic      seedClear;
  logic      violation;

  cf_guard_ctrl #(
    .VIOL_LIMIT (VIOL_LIMIT)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .loWindow    (loWindow),
    .sampleValid (sampleValid),
    .cycleEnd    (cycleEnd),
    .detectEn    (detectEn),
    .faultClear  (faultClear),
    .violation   (violation),
    .strb        (strb),
    .seedClear   (seedClear),
    .faultFlag   (faultFlag)
  );

  cf_guard_datapath #(
    .SAMPLE_W  (SAMPLE_W),
    .WIN_CNT_W (WIN_CNT_W),
    .EMA_SHIFT (EMA_SHIFT)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .sampleData (sampleData),
    .seedClear  (seedClear),
    .violation  (violation)
  );

endmodule

// File: tb/cf_overcurrent_guard_test.sv
module cf_overcurrent_guard_test;

  localparam int SW = 10;
  localparam int LIMIT = 70;
  localparam int SHIFT = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [SW-1:0] sampleData = '0;
  logic          sampleValid = 1'b0;
  logic          loWindow = 1'b0;
  logic          cycleEnd = 1'b0;
  logic          detectEn = 1'b0;
  logic          faultClear = 1'b0;
  logic          faultFlag;

  cf_overcurrent_guard uut (
    .clk(clk), .rstN(rstN), .sampleData(sampleData), .sampleValid(sampleValid),
    .loWindow(loWindow), .cycleEnd(cycleEnd), .detectEn(detectEn),
    .faultClear(faultClear), .faultFlag(faultFlag)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic  exp;
    string tag;
  } expItem_t;

  expItem_t sbq[$];
  int nChecks = 0;
  int nFails  = 0;

  // Reference model state, built from the requirements.
  int mAvgAcc = 0;
  bit mSeeded = 0;
  int mCnt    = 0;
  bit mFault  = 0;

  int flatW[8]  = '{100, 100, 100, 100, 0, 0, 0, 0};
  int violW[8]  = '{50, 50, 50, 50, 50, 50, 50, 1000};
  int seedW[8]  = '{0, 0, 0, 900, 0, 0, 0, 0};
  int eqW[8]    = '{300, 0, 0, 0, 0, 0, 0, 0};
  int aboveW[8] = '{301, 0, 0, 0, 0, 0, 0, 0};

  task automatic check(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: faultFlag=%0b expected %0b", tag, act, exp);
    end
  endtask

  // One switching cycle: window with n samples, optional stray sample, strobe.
  task automatic runWindow(input int vals[8], input int n, input int stray, input string tag);
    int peak = 0;
    int sum  = 0;
    int mean;
    bit viol;
    expItem_t it;
    @(negedge clk);
    loWindow = 1'b1;
    if (n == 0) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sampleValid = 1'b1;
      sampleData  = SW'(vals[i]);
      if (vals[i] > peak) peak = vals[i];
      sum += vals[i];
      @(negedge clk);
    end
    sampleValid = 1'b0;
    loWindow    = 1'b0;
    if (stray > 0) begin
      sampleValid = 1'b1;
      sampleData  = SW'(stray);
      @(negedge clk);
      sampleValid = 1'b0;
    end
    @(negedge clk);
    mean = (n > 0) ? sum / n : 0;
    viol = mSeeded && (n > 0) && (peak > 3 * (mAvgAcc >> SHIFT));
    if (!detectEn) mCnt = 0;
    else if (viol) begin
      if (mCnt == LIMIT - 1) begin mFault = 1; mCnt = 0; end
      else mCnt++;
    end else mCnt = 0;
    if (n > 0) begin
      if (!mSeeded) begin mAvgAcc = mean << SHIFT; mSeeded = 1; end
      else mAvgAcc = mAvgAcc - (mAvgAcc >> SHIFT) + mean;
    end
    it.exp = mFault;
    it.tag = tag;
    sbq.push_back(it);
    cycleEnd = 1'b1;
    @(negedge clk);
    cycleEnd = 1'b0;
  endtask

  task automatic repeatWin(input int times, input int vals[8], input int n,
                           input int stray, input string tag);
    for (int k = 0; k < times; k++) runWindow(vals, n, stray, tag);
  endtask

  task automatic clearFault();
    @(negedge clk);
    faultClear = 1'b1;
    mFault = 0; mCnt = 0; mSeeded = 0; mAvgAcc = 0;
    @(negedge clk);
    faultClear = 1'b0;
    check(faultFlag, 1'b0, "R9 clear");
  endtask

  // Monitor: compare the fault one edge after each end-of-cycle strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (cycleEnd) begin
        expItem_t it;
        @(negedge clk);
        if (sbq.size() == 0) begin
          nChecks++; nFails++;
          $display("FAIL scoreboard: empty queue");
        end else begin
          it = sbq.pop_front();
          check(faultFlag, it.exp, it.tag);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(faultFlag, 1'b0, "R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    check(faultFlag, 1'b0, "R1 after reset");
    detectEn = 1'b1;

    repeatWin(5, flatW, 4, 0, "R4 seed flat");
    repeatWin(75, flatW, 4, 1023, "R2 stray out-of-window samples");

    repeatWin(60, violW, 8, 0, "R6 first run");
    repeatWin(1, flatW, 4, 0, "R3 peak restart breaks run");
    repeatWin(69, violW, 8, 0, "R6 second run short");
    repeatWin(1, violW, 8, 0, "R7 seventieth violation");
    repeatWin(3, flatW, 4, 0, "R9 latched");
    detectEn = 1'b0;
    repeatWin(2, flatW, 4, 0, "R9 latched while disarmed");
    detectEn = 1'b1;
    clearFault();

    repeatWin(70, seedW, 4, 0, "R4 seeding first cycle");
    repeatWin(1, seedW, 4, 0, "R7 after seeding");
    clearFault();

    repeatWin(1, flatW, 4, 0, "R4 seed 100");
    repeatWin(70, eqW, 3, 0, "R5 peak equals 3x");
    repeatWin(70, aboveW, 3, 0, "R5 peak 3x plus one");
    clearFault();

    repeatWin(1, flatW, 4, 0, "R4 seed");
    detectEn = 1'b0;
    repeatWin(80, violW, 8, 0, "R8 disarmed");
    detectEn = 1'b1;
    repeatWin(40, violW, 8, 0, "R8 armed run");
    detectEn = 1'b0;
    repeatWin(1, violW, 8, 0, "R8 disarm gap");
    detectEn = 1'b1;
    repeatWin(40, violW, 8, 0, "R8 restarted run");
    repeatWin(30, violW, 8, 0, "R8 count from zero");
    clearFault();

    repeatWin(1, flatW, 4, 0, "R4 seed");
    repeatWin(60, violW, 8, 0, "R10 run before empty");
    repeatWin(1, violW, 0, 0, "R10 empty window");
    repeatWin(60, violW, 8, 0, "R10 run after empty");

    repeat (4) @(negedge clk);
    if (sbq.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL scoreboard: %0d items left, expected 0", sbq.size());
    end
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule